// File: doc/BRIEF.md
# Paged Instruction Address Sequencer

This block produces the fetch address for a small 8-bit controller core. It keeps a 13-bit program counter that steps forward once per instruction cycle and is redirected by decoded strobes. The strobes are jump, subroutine call, subroutine return, interrupt entry and a direct write of the counter's low byte. A 5-bit page latch holds the upper address bits. Software writes the latch and every redirect that cannot supply a full address takes its upper bits from it. Jump and call carry only an 11-bit in-page field, so the latch provides bits 12 and 11.

Call and interrupt entry save the address of the next sequential instruction on an internal eight-entry return stack. A return restores all 13 bits from that stack. The stack is a ring: once it is full, each further push overwrites the oldest entry. No flag reports overflow or underflow, and the stack pointer cannot be read by software.

Top module: `pc_sequencer`

## Requirements
- R1: While reset is asserted the program counter, the page latch, the stack pointer and all stack entries are cleared to zero, so that a return issued straight after reset yields address 0.
- R2: An increment strobe alone advances the counter by one modulo 2^13, so 0x1FFF is followed by 0x0000.
- R3: A jump loads the counter with {latch bit 4, latch bit 3, imm[10:0]}. Latch bit 4 goes to counter bit 12, latch bit 3 to bit 11, and latch bits 2..0 are not used.
- R4: A call loads the same target as a jump and pushes the current counter plus one onto the return stack.
- R5: A return pops the most recent stack entry into all 13 counter bits, whatever value the latch holds.
- R6: An interrupt pushes the current counter plus one and loads the counter with 0x0004.
- R7: A low-byte write sets counter bits 7..0 to data[7:0] and bits 12..8 to latch bits 4..0.
- R8: A latch write loads latch bits 4..0 from data[4:0] at the clock edge. Any redirect in the same cycle uses the previous latch value. Pushes and pops never alter the latch.
- R9: The stack holds eight entries in a ring. The ninth push overwrites the entry of the first push, and pops then return the most recent eight values before wrapping around to them again.
- R10: When several strobes are active in one cycle, only the highest one acts, in the order interrupt, call, jump, return, low-byte write, increment. A call or return that loses does not push or pop. With no strobe the counter holds its value.
- R11: The readable low-byte output always equals bits 7..0 of the fetch address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inc_i | input | 1 | Advance to the next sequential address |
| goto_i | input | 1 | Jump within the page selected by the latch |
| call_i | input | 1 | Jump and save the return address |
| ret_i | input | 1 | Restore the address from the return stack |
| irq_i | input | 1 | Enter the interrupt vector and save the return address |
| pcl_wr_i | input | 1 | Write the counter's low byte from the data bus |
| lat_wr_i | input | 1 | Write the page latch from the data bus |
| imm_i | input | 11 | In-page branch target field |
| data_i | input | 8 | Data bus for low-byte and latch writes |
| fetch_addr_o | output | 13 | Current fetch address |
| pcl_o | output | 8 | Readable low byte of the counter |

## Verification
The hardest case to reach is the ring wrap of the return stack. The return stack cannot be seen from the ports, so the only way to observe an overwritten entry is to nest calls more deeply than the stack holds and then unwind. The stimulus therefore issues ten calls to distinct targets, with increments in between so that every saved address differs. It then issues ten returns, and the later returns must come back to the two newest addresses in place of the overwritten oldest ones. Combined strobes are driven so that a losing call or return would shift the stack, and the returns that follow expose any such shift. A randomized phase is compared against the behavioural model on every clock.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

   typedef enum logic [2:0] {
      OP_HOLD = 3'd0,
      OP_INC  = 3'd1,
      OP_PCL  = 3'd2,
      OP_RET  = 3'd3,
      OP_GOTO = 3'd4,
      OP_CALL = 3'd5,
      OP_IRQ  = 3'd6
   } pc_op_e;

endpackage

// File: rtl/pcseq_prio.sv
module pcseq_prio
   import pcseq_pkg::*;
(
   input  logic   inc_i,
   input  logic   goto_i,
   input  logic   call_i,
   input  logic   ret_i,
   input  logic   irq_i,
   input  logic   pcl_wr_i,
   output pc_op_e op_o
);

   always_comb begin
      if (irq_i)         op_o = OP_IRQ;
      else if (call_i)   op_o = OP_CALL;
      else if (goto_i)   op_o = OP_GOTO;
      else if (ret_i)    op_o = OP_RET;
      else if (pcl_wr_i) op_o = OP_PCL;
      else if (inc_i)    op_o = OP_INC;
      else               op_o = OP_HOLD;
   end

endmodule

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
   parameter int DEPTH = 8,
   parameter int WIDTH = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic             pop_i,
   input  logic [WIDTH-1:0] push_data_i,
   output logic [WIDTH-1:0] top_o
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam bit POW2  = ((DEPTH & (DEPTH - 1)) == 0);

   if (DEPTH < 2) begin : g_bad_depth
      $error("pcseq_stack: DEPTH must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("pcseq_stack: WIDTH must be positive");
   end

   logic [WIDTH-1:0] mem_q [DEPTH];
   logic [PTR_W-1:0] sp_q;
   logic [PTR_W-1:0] sp_up;
   logic [PTR_W-1:0] sp_dn;

   if (POW2) begin : g_wrap_free
      assign sp_up = sp_q + PTR_W'(1);
      assign sp_dn = sp_q - PTR_W'(1);
   end else begin : g_wrap_cmp
      assign sp_up = (sp_q == PTR_W'(DEPTH - 1)) ? '0 : sp_q + PTR_W'(1);
      assign sp_dn = (sp_q == '0) ? PTR_W'(DEPTH - 1) : sp_q - PTR_W'(1);
   end

   assign top_o = mem_q[sp_dn];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp_q <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            mem_q[i] <= '0;
         end
      end else if (push_i) begin
         mem_q[sp_q] <= push_data_i;
         sp_q        <= sp_up;
      end else if (pop_i) begin
         sp_q <= sp_dn;
      end
   end

endmodule

// File: rtl/pcseq_next.sv
module pcseq_next
   import pcseq_pkg::*;
#(
   parameter int PC_W   = 13,
   parameter int IMM_W  = 11,
   parameter int DATA_W = 8,
   parameter int VECTOR = 4
) (
   input  pc_op_e                 op_i,
   input  logic [PC_W-1:0]        pc_i,
   input  logic [PC_W-DATA_W-1:0] lat_i,
   input  logic [IMM_W-1:0]       imm_i,
   input  logic [DATA_W-1:0]      data_i,
   input  logic [PC_W-1:0]        top_i,
   output logic [PC_W-1:0]        next_o,
   output logic [PC_W-1:0]        ret_addr_o,
   output logic                   push_o,
   output logic                   pop_o
);

   localparam int LAT_W  = PC_W - DATA_W;
   localparam int PAGE_W = PC_W - IMM_W;

   logic [PC_W-1:0] target;
   logic [PC_W-1:0] seq;

   assign target     = {lat_i[LAT_W-1 -: PAGE_W], imm_i};
   assign seq        = pc_i + PC_W'(1);
   assign ret_addr_o = seq;

   always_comb begin
      next_o = pc_i;
      push_o = 1'b0;
      pop_o  = 1'b0;
      unique case (op_i)
         OP_IRQ: begin
            next_o = PC_W'(VECTOR);
            push_o = 1'b1;
         end
         OP_CALL: begin
            next_o = target;
            push_o = 1'b1;
         end
         OP_GOTO: next_o = target;
         OP_RET: begin
            next_o = top_i;
            pop_o  = 1'b1;
         end
         OP_PCL:  next_o = {lat_i, data_i};
         OP_INC:  next_o = seq;
         default: next_o = pc_i;
      endcase
   end

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
   parameter int PC_W   = 13,
   parameter int IMM_W  = 11,
   parameter int DATA_W = 8,
   parameter int DEPTH  = 8,
   parameter int VECTOR = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc_i,
   input  logic              goto_i,
   input  logic              call_i,
   input  logic              ret_i,
   input  logic              irq_i,
   input  logic              pcl_wr_i,
   input  logic              lat_wr_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [PC_W-1:0]   fetch_addr_o,
   output logic [DATA_W-1:0] pcl_o
);

   localparam int LAT_W = PC_W - DATA_W;

   if (PC_W <= DATA_W) begin : g_bad_pc
      $error("pc_sequencer: PC_W must exceed DATA_W");
   end
   if (PC_W <= IMM_W || IMM_W < DATA_W) begin : g_bad_imm
      $error("pc_sequencer: need DATA_W <= IMM_W < PC_W");
   end
   if (VECTOR >= (1 << PC_W)) begin : g_bad_vec
      $error("pc_sequencer: VECTOR outside address space");
   end

   pcseq_pkg::pc_op_e op;
   logic [PC_W-1:0]   pc_q;
   logic [PC_W-1:0]   pc_d;
   logic [LAT_W-1:0]  lat_q;
   logic [PC_W-1:0]   stack_top;
   logic [PC_W-1:0]   ret_addr;
   logic              do_push;
   logic              do_pop;

   pcseq_prio prio_i (
      .inc_i    (inc_i),
      .goto_i   (goto_i),
      .call_i   (call_i),
      .ret_i    (ret_i),
      .irq_i    (irq_i),
      .pcl_wr_i (pcl_wr_i),
      .op_o     (op)
   );

   pcseq_next #(
      .PC_W   (PC_W),
      .IMM_W  (IMM_W),
      .DATA_W (DATA_W),
      .VECTOR (VECTOR)
   ) next_i (
      .op_i       (op),
      .pc_i       (pc_q),
      .lat_i      (lat_q),
      .imm_i      (imm_i),
      .data_i     (data_i),
      .top_i      (stack_top),
      .next_o     (pc_d),
      .ret_addr_o (ret_addr),
      .push_o     (do_push),
      .pop_o      (do_pop)
   );

   pcseq_stack #(
      .DEPTH (DEPTH),
      .WIDTH (PC_W)
   ) stack_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (do_push),
      .pop_i       (do_pop),
      .push_data_i (ret_addr),
      .top_o       (stack_top)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q  <= '0;
         lat_q <= '0;
      end else begin
         pc_q <= pc_d;
         if (lat_wr_i) begin
            lat_q <= data_i[LAT_W-1:0];
         end
      end
   end

   assign fetch_addr_o = pc_q;
   assign pcl_o        = pc_q[DATA_W-1:0];

endmodule

// File: rtl/pcseq_chk.sv
module pcseq_chk #(
   parameter int PC_W   = 13,
   parameter int IMM_W  = 11,
   parameter int DATA_W = 8,
   parameter int VECTOR = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   inc_i,
   input logic                   goto_i,
   input logic                   call_i,
   input logic                   ret_i,
   input logic                   irq_i,
   input logic                   pcl_wr_i,
   input logic                   lat_wr_i,
   input logic [IMM_W-1:0]       imm_i,
   input logic [DATA_W-1:0]      data_i,
   input logic [PC_W-1:0]        fetch_addr_o,
   input logic [PC_W-DATA_W-1:0] lat_q
);

   localparam int LAT_W  = PC_W - DATA_W;
   localparam int PAGE_W = PC_W - IMM_W;

   logic any_strobe;
   logic only_call;
   logic only_ret;
   assign any_strobe = inc_i | goto_i | call_i | ret_i | irq_i | pcl_wr_i;
   assign only_call  = call_i & ~irq_i;
   assign only_ret   = ret_i & ~(irq_i | call_i | goto_i);

   // R2
   inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !(goto_i || call_i || ret_i || irq_i || pcl_wr_i))
      |=> fetch_addr_o == PC_W'($past(fetch_addr_o) + PC_W'(1)));

   // R3
   goto_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (goto_i && !irq_i && !call_i)
      |=> fetch_addr_o == {$past(lat_q[LAT_W-1 -: PAGE_W]), $past(imm_i)});

   // R5
   call_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (only_ret && $past(only_call))
      |=> fetch_addr_o == PC_W'($past(fetch_addr_o, 2) + PC_W'(1)));

   // R6
   irq_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_i |=> fetch_addr_o == PC_W'(VECTOR));

   // R7
   low_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pcl_wr_i && !(irq_i || call_i || goto_i || ret_i))
      |=> fetch_addr_o == {$past(lat_q), $past(data_i)});

   // R8
   latch_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lat_wr_i |=> $stable(lat_q));

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !any_strobe |=> $stable(fetch_addr_o));

endmodule

bind pc_sequencer pcseq_chk #(
   .PC_W   (PC_W),
   .IMM_W  (IMM_W),
   .DATA_W (DATA_W),
   .VECTOR (VECTOR)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .inc_i        (inc_i),
   .goto_i       (goto_i),
   .call_i       (call_i),
   .ret_i        (ret_i),
   .irq_i        (irq_i),
   .pcl_wr_i     (pcl_wr_i),
   .lat_wr_i     (lat_wr_i),
   .imm_i        (imm_i),
   .data_i       (data_i),
   .fetch_addr_o (fetch_addr_o),
   .lat_q        (lat_q)
);

// File: tb/pc_sequencer_tb_top.sv
`timescale 1ns/100ps
module pc_sequencer_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        inc_i = 0, goto_i = 0, call_i = 0, ret_i = 0;
   logic        irq_i = 0, pcl_wr_i = 0, lat_wr_i = 0;
   logic [10:0] imm_i = '0;
   logic [7:0]  data_i = '0;
   logic [12:0] fetch_addr_o;
   logic [7:0]  pcl_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // behavioural reference
   int m_pc = 0;
   int m_lat = 0;
   int m_sp = 0;
   int m_stk [8];

   always #2.5 clk = ~clk;

   pc_sequencer dut_i (
      .clk(clk), .rst_n(rst_n), .inc_i(inc_i), .goto_i(goto_i), .call_i(call_i),
      .ret_i(ret_i), .irq_i(irq_i), .pcl_wr_i(pcl_wr_i), .lat_wr_i(lat_wr_i),
      .imm_i(imm_i), .data_i(data_i), .fetch_addr_o(fetch_addr_o), .pcl_o(pcl_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic m_push(input int v);
      m_stk[m_sp] = v & 16'h1FFF;
      m_sp = (m_sp + 1) % 8;
   endtask

   task automatic step(input bit s_inc, input bit s_goto, input bit s_call,
                       input bit s_ret, input bit s_irq, input bit s_pcl,
                       input bit s_lat, input int imm, input int d,
                       input string tag);
      int tgt;
      inc_i = s_inc; goto_i = s_goto; call_i = s_call; ret_i = s_ret;
      irq_i = s_irq; pcl_wr_i = s_pcl; lat_wr_i = s_lat;
      imm_i = imm[10:0]; data_i = d[7:0];
      @(posedge clk);
      tgt = ((m_lat >> 3) & 3) << 11 | (imm & 16'h7FF);
      if (s_irq) begin
         m_push(m_pc + 1); m_pc = 4;
      end else if (s_call) begin
         m_push(m_pc + 1); m_pc = tgt;
      end else if (s_goto) begin
         m_pc = tgt;
      end else if (s_ret) begin
         m_sp = (m_sp + 7) % 8; m_pc = m_stk[m_sp];
      end else if (s_pcl) begin
         m_pc = (m_lat << 8) | (d & 255);
      end else if (s_inc) begin
         m_pc = (m_pc + 1) & 16'h1FFF;
      end
      if (s_lat) m_lat = d & 31;
      #1;
      chk(tag, int'(fetch_addr_o), m_pc);
      chk("R11", int'(pcl_o), m_pc & 255);
   endtask

   task automatic t_idle(input string tag);     step(0,0,0,0,0,0,0,0,0,tag);   endtask
   task automatic t_inc(input string tag);      step(1,0,0,0,0,0,0,0,0,tag);   endtask
   task automatic t_goto(input int a, input string tag); step(0,1,0,0,0,0,0,a,0,tag); endtask
   task automatic t_call(input int a, input string tag); step(0,0,1,0,0,0,0,a,0,tag); endtask
   task automatic t_ret(input string tag);      step(0,0,0,1,0,0,0,0,0,tag);   endtask
   task automatic t_irq(input string tag);      step(0,0,0,0,1,0,0,0,0,tag);   endtask
   task automatic t_pcl(input int d, input string tag);  step(0,0,0,0,0,1,0,0,d,tag); endtask
   task automatic t_lat(input int d, input string tag);  step(0,0,0,0,0,0,1,0,d,tag); endtask

   initial begin
      for (int i = 0; i < 8; i++) m_stk[i] = 0;
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      chk("R1", int'(fetch_addr_o), 0);
      chk("R1", int'(pcl_o), 0);
      rst_n = 1'b1;
      t_ret("R1");
      repeat (3) t_inc("R2");
      t_lat(8'h1F, "R8");
      t_pcl(8'hFF, "R7");
      t_inc("R2");
      t_idle("R10");
      // R3: page bits from latch bits 4 and 3
      t_lat(8'h18, "R8");  t_goto(11'h5A5, "R3");
      t_lat(8'h08, "R8");  t_goto(11'h123, "R3");
      t_lat(8'h10, "R8");  t_goto(11'h7FF, "R3");
      t_lat(8'hE7, "R8");  t_goto(11'h001, "R3");
      t_pcl(8'h40, "R7");
      // R4 / R5
      t_lat(8'h08, "R8");
      t_call(11'h300, "R4");
      t_lat(8'h1F, "R8");
      t_ret("R5");
      t_call(11'h010, "R4"); t_inc("R2");
      t_call(11'h020, "R4"); t_inc("R2");
      t_call(11'h030, "R4");
      t_ret("R5"); t_ret("R5"); t_ret("R5");
      // R6
      t_inc("R2");
      t_irq("R6");
      t_ret("R6");
      // R9: ring wrap with ten nested calls
      for (int i = 1; i <= 10; i++) begin
         t_call(i * 16, "R9");
         t_inc("R9");
      end
      for (int i = 0; i < 10; i++) t_ret("R9");
      // R8: same-cycle latch write uses old value
      t_lat(8'h00, "R8");
      step(0,1,0,0,0,0,1,11'h055,8'h18,"R8");
      t_goto(11'h055, "R8");
      step(0,0,1,0,0,0,1,11'h066,8'h00,"R8");
      t_ret("R8");
      // R10: priority combinations
      step(1,1,1,1,1,1,0,11'h111,8'h22,"R10");
      step(0,1,1,0,0,0,0,11'h222,8'h00,"R10");
      step(0,1,0,1,0,0,0,11'h333,8'h00,"R10");
      step(0,0,0,1,0,1,0,0,8'h77,"R10");
      step(1,0,0,0,0,1,0,0,8'h99,"R10");
      t_idle("R10");
      t_ret("R10"); t_ret("R10"); t_ret("R10");
      // random phase against the model
      for (int n = 0; n < 400; n++) begin
         int r;
         r = $urandom_range(0, 99);
         step(r < 50, r >= 50 && r < 60, r >= 60 && r < 72, r >= 72 && r < 86,
              r >= 86 && r < 90, r >= 90 && r < 95, $urandom_range(0, 3) == 0,
              $urandom_range(0, 2047), $urandom_range(0, 255), "R10");
      end
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule